// File: doc/BRIEF.md
# Memory Bus Handshake Master

This block connects a processor core to an external word-wide memory and runs one read or one write at a time over dedicated address, data and strobe lines. The core raises a request with an address, a direction bit and, for a write, the word to store. The master then drives the address and the request strobe together with either the read strobe or the write strobe, and holds that state until the memory answers with its ready line.

The memory may insert any number of wait cycles before it answers. When ready is seen, the master captures the read word into an output register (or simply accepts the write acknowledgement), drops all strobes and gives the core a single-cycle completion pulse. A new request is taken in the cycle after that pulse. The shared data bus is split into separate write-data and read-data ports. The address and data widths are parameters, with both set to 16 bits by default.

Top module: `membus_master`

## Requirements
- R1: When the master is idle and `core_req` is high at a clock edge, from the next cycle on `mem_req` is high, `mem_addr` equals the requested address, `mem_rd` equals the inverse of `core_we` and `mem_wr` equals `core_we` (1 = write). For a write, `mem_wdata` carries the core's word.
- R2: `mem_rd` and `mem_wr` are never high together, and neither is high while `mem_req` is low.
- R3: While `mem_req` is high and `mem_ready` is low, the address, write data, strobes and request stay unchanged in the next cycle, however many wait cycles the memory inserts.
- R4: After a clock edge where `mem_req` and `mem_ready` are both high, `mem_req`, `mem_rd` and `mem_wr` are low and `core_done` is high for exactly one cycle.
- R5: A completed read loads `core_rdata` with the `mem_rdata` value present at the completing edge. A completed write and any cycle without a completion leave `core_rdata` unchanged.
- R6: `core_req` is ignored while a transfer is in progress and during the `core_done` cycle. No extra memory transaction results. A request held through the `core_done` cycle is taken one cycle later.
- R7: Synchronous active-high `rst` returns the master to idle in the following cycle, with all memory strobes low, `core_done` low and `core_rdata` zero, even when it arrives mid-transfer.
- R8: Every read returns the word most recently written to the same address through the master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core transfer request, sampled when idle |
| core_we | input | 1 | Direction: 1 = write, 0 = read |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Word to write |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_req | output | 1 | Memory request strobe |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | DATA_W | Write data lines |
| mem_ready | input | 1 | Memory completion signal |
| mem_rdata | input | DATA_W | Read data lines |

## Verification
The bench runs the master against a memory model that inserts random wait states, and it aims at zero-wait answers, long stalls, requests issued during the completion cycle, and stray requests raised mid-transfer. A master that let its address or strobes drift during a stall would write or read the wrong word. One that took a stray request would start a second memory transaction and break the transaction count. A reset during a long stall checks that the strobes are released and the read register is cleared. A master that kept its state would leave the request hanging. Reads are compared against a scoreboard of earlier writes, and writes must leave the read register unchanged.

// File: rtl/membus_pkg.sv
package membus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } bus_state_e;

  // Sequencing of one transfer: idle -> busy -> done -> idle
  function automatic bus_state_e next_state(input bus_state_e cur,
                                            input logic req,
                                            input logic ready);
    bus_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE: if (req) nxt = ST_BUSY;
      ST_BUSY: if (ready) nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Strobe encoding legal on the bus
  function automatic logic strobes_legal(input logic req,
                                         input logic rd,
                                         input logic wr);
    return !(rd && wr) && (req || (!rd && !wr));
  endfunction

endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
  import membus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic core_req,
  input  logic mem_ready,
  output logic accept,
  output logic complete
);

  bus_state_e state_q;

  assign accept   = (state_q == ST_IDLE) && core_req;
  assign complete = (state_q == ST_BUSY) && mem_ready;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= next_state(state_q, core_req, mem_ready);
  end

endmodule

// File: rtl/membus_datapath.sv
module membus_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              complete,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_req,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_req    <= 1'b0;
      mem_rd     <= 1'b0;
      mem_wr     <= 1'b0;
      core_done  <= 1'b0;
      core_rdata <= '0;
    end else begin
      core_done <= complete;
      if (accept) begin
        mem_addr  <= core_addr;
        mem_wdata <= core_wdata;
        mem_req   <= 1'b1;
        mem_rd    <= !core_we;
        mem_wr    <= core_we;
      end else if (complete) begin
        mem_req <= 1'b0;
        mem_rd  <= 1'b0;
        mem_wr  <= 1'b0;
        if (mem_rd) core_rdata <= mem_rdata;
      end
    end
  end

endmodule

// File: rtl/membus_master.sv
module membus_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_done,
  output logic [DATA_W-1:0] core_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_req,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);

  // Named internal events, visible to the bound checker
  logic accept;
  logic complete;

  membus_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .core_req  (core_req),
    .mem_ready (mem_ready),
    .accept    (accept),
    .complete  (complete)
  );

  membus_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .accept     (accept),
    .complete   (complete),
    .core_we    (core_we),
    .core_addr  (core_addr),
    .core_wdata (core_wdata),
    .mem_rdata  (mem_rdata),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_req    (mem_req),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .core_done  (core_done),
    .core_rdata (core_rdata)
  );

endmodule

// File: rtl/membus_master_chk.sv
module membus_master_chk
  import membus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              core_we,
  input logic [ADDR_W-1:0] core_addr,
  input logic [DATA_W-1:0] core_wdata,
  input logic              core_done,
  input logic [DATA_W-1:0] core_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_req,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              accept,
  input logic              complete
);

  assert_launch_R1: assert property (@(posedge clk) disable iff (rst)
    accept |=> mem_req && mem_addr == $past(core_addr)
               && mem_wr == $past(core_we) && mem_rd == !$past(core_we)
               && (!mem_wr || mem_wdata == $past(core_wdata)));

  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (rst)
    strobes_legal(mem_req, mem_rd, mem_wr));

  assert_wait_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                                && $stable(mem_rd) && $stable(mem_wr));

  assert_release_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req && !mem_rd && !mem_wr && core_done);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    core_done |=> !core_done);

  assert_read_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && mem_rd) |=> core_rdata == $past(mem_rdata));

  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(complete && mem_rd) |=> $stable(core_rdata));

  assert_no_accept_in_done_R6: assert property (@(posedge clk) disable iff (rst)
    core_done |=> !mem_req);

  assert_reset_idle_R7: assert property (@(posedge clk)
    rst |=> !mem_req && !mem_rd && !mem_wr && !core_done && core_rdata == '0);

endmodule

bind membus_master membus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_we    (core_we),
  .core_addr  (core_addr),
  .core_wdata (core_wdata),
  .core_done  (core_done),
  .core_rdata (core_rdata),
  .mem_addr   (mem_addr),
  .mem_req    (mem_req),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .mem_wdata  (mem_wdata),
  .mem_ready  (mem_ready),
  .mem_rdata  (mem_rdata),
  .accept     (accept),
  .complete   (complete)
);

// File: tb/membus_master_test.sv
`timescale 1ns/1ps
module membus_master_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int MDEPTH = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          core_req = 1'b0;
  logic          core_we = 1'b0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic          core_done;
  logic [DW-1:0] core_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_req, mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ready;
  logic [DW-1:0] mem_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  membus_master #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .core_req(core_req), .core_we(core_we),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_done(core_done),
    .core_rdata(core_rdata), .mem_addr(mem_addr), .mem_req(mem_req),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Behavioural memory with wait states
  logic [DW-1:0] mem_arr [MDEPTH];
  logic          ready_q = 1'b0;
  logic [DW-1:0] rdata_q = '0;
  logic          armed = 1'b0;
  int            cnt = 0;
  int            force_wait = -1;
  int            txn_count = 0;

  assign mem_ready = ready_q;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    int w;
    if (rst) begin
      ready_q <= 1'b0;
      armed   <= 1'b0;
    end else if (ready_q) begin
      ready_q <= 1'b0;
      armed   <= 1'b0;
    end else if (mem_req) begin
      if (!armed) w = (force_wait >= 0) ? force_wait : int'($urandom_range(0, 4));
      else        w = cnt;
      if (w == 0) begin
        ready_q <= 1'b1;
        rdata_q <= mem_arr[mem_addr[7:0]];
        if (mem_wr) mem_arr[mem_addr[7:0]] <= mem_wdata;
        txn_count <= txn_count + 1;
      end else begin
        armed <= 1'b1;
        cnt   <= w - 1;
      end
    end
  end

  // Scoreboard
  logic [DW-1:0] expm [MDEPTH];

  function automatic logic [7:0] sb_idx(input logic [AW-1:0] a);
    return a[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // One transfer. poke: raise a stray request mid-transfer.
  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    bit from_done;
    int n;
    int t0;
    logic [DW-1:0] prev_rd;
    from_done = core_done;
    prev_rd = core_rdata;
    core_req = 1'b1; core_we = we; core_addr = a; core_wdata = d;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1 && from_done) chk(core_done == 1'b0, "R4 done one cycle", 32'(core_done), 0);
    end while (!mem_req && n < 10);
    chk(n == (from_done ? 2 : 1), "R6 accept latency", n, from_done ? 2 : 1);
    chk(mem_addr == a, "R1 address", 32'(mem_addr), 32'(a));
    chk(mem_rd == !we && mem_wr == we, "R1 strobes", {30'd0, mem_rd, mem_wr}, {30'd0, !we, we});
    if (we) chk(mem_wdata == d, "R1 write data", 32'(mem_wdata), 32'(d));
    t0 = txn_count;
    core_req = 1'b0;
    n = 0;
    forever begin
      if (poke && n == 0) begin core_req = 1'b1; core_addr = ~a; core_we = !we; end
      @(negedge clk);
      core_req = 1'b0; core_addr = a; core_we = we;
      if (core_done) break;
      n++;
      chk(mem_req && mem_addr == a && (!we || mem_wdata == d) && !(mem_rd && mem_wr),
          "R3/R2 hold during wait", 32'(mem_addr), 32'(a));
      if (n > 100) begin
        chk(0, "watchdog R3", n, 100);
        return;
      end
    end
    chk(!mem_req && !mem_rd && !mem_wr, "R4 release", {29'd0, mem_req, mem_rd, mem_wr}, 0);
    chk(txn_count - t0 == 1, "R6 single transaction", txn_count - t0, 1);
    if (we) begin
      chk(core_rdata == prev_rd, "R5 write keeps rdata", 32'(core_rdata), 32'(prev_rd));
      expm[sb_idx(a)] = d;
    end else begin
      chk(core_rdata == expm[sb_idx(a)], "R8 read data", 32'(core_rdata), 32'(expm[sb_idx(a)]));
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < MDEPTH; i++) begin mem_arr[i] = '0; expm[i] = '0; end
    repeat (3) @(negedge clk);
    chk(!mem_req && !mem_rd && !mem_wr && !core_done && core_rdata == '0,
        "R7 reset state", {28'd0, mem_req, mem_rd, mem_wr, core_done}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Directed: zero wait, long wait, back-to-back
    force_wait = 0;
    xfer(1'b1, 16'h0011, 16'hA5A5, 1'b0);
    xfer(1'b0, 16'h0011, 16'h0000, 1'b0);
    force_wait = 12;
    xfer(1'b1, 16'h12FE, 16'h5A5A, 1'b0);
    xfer(1'b0, 16'h00FE, 16'h0000, 1'b0);
    // Stray request during a stalled transfer
    force_wait = 5;
    xfer(1'b1, 16'h0042, 16'h1357, 1'b1);
    xfer(1'b0, 16'h0042, 16'h0000, 1'b1);
    // Request from idle after a gap
    @(negedge clk); @(negedge clk);
    force_wait = -1;
    xfer(1'b0, 16'h0011, 16'h0000, 1'b0);

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = {8'($urandom), 3'b000, 5'($urandom)};
      xfer(($urandom_range(0, 1) == 1), a, 16'($urandom), ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 5) == 0) @(negedge clk);
    end

    // Reset in the middle of a stalled read
    force_wait = 20;
    core_req = 1'b1; core_we = 1'b0; core_addr = 16'h0011;
    @(negedge clk);
    core_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!mem_req && !mem_rd && !mem_wr && !core_done && core_rdata == '0,
        "R7 mid-transfer reset", {28'd0, mem_req, mem_rd, mem_wr, core_done}, 0);
    rst = 1'b0;
    force_wait = 1;
    @(negedge clk);
    chk(!mem_req, "R7 idle after reset", 32'(mem_req), 0);
    xfer(1'b0, 16'h0042, 16'h0000, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule